// File: doc/BRIEF.md
# ATM Cell Header HEC Checker

This block sits on the receive side of a cell path, after cell boundaries are already known. Cells of 53 bytes arrive one byte per clock when `in_valid` is high, and `in_sof` marks the first byte of each cell. The block computes a CRC-8 over the four header bytes and checks it against the fifth byte. That fifth byte can optionally have the coset pattern removed before the comparison.

A two-state mode machine governs what happens to an errored header. In correcting mode, a single-bit error is repaired. In detecting mode, every errored header is reported and none is repaired. Cells that cannot be repaired can be dropped, and the fifth byte can be rebuilt on the way out. Every cell leaves with one status flag: clean, repaired or unrepairable.

Each cell is held in a two-bank buffer for one full cell. This gives the header time to be repaired before its first byte is sent on.

Top module: `hec_cell_checker`

## Requirements
- R1: The check byte is a CRC-8 with generator x^8+x^2+x+1. The CRC starts at zero and runs over header bytes 0 to 3, most significant bit first. It is compared with byte 4 of the cell. On a match, the cell is forwarded unchanged with `out_hdr_ok` set.
- R2: When `cfg_coset_en` is 1, the received byte 4 is XORed with 0x55 before the comparison.
- R3: After reset the block is in correcting mode. A header with exactly one flipped bit is repaired when the block is in correcting mode and `cfg_correct_en` is 1. The flipped bit may be any of the 40 bits in bytes 0 to 4. The repaired bytes are output with `out_corrected` set, and the block then enters detecting mode.
- R4: In correcting mode, a header with two flipped bits is flagged `out_uncorr`, and the block enters detecting mode.
- R5: In detecting mode, every errored header is flagged `out_uncorr`. The first error-free header returns the block to correcting mode.
- R6: With `cfg_correct_en` at 0, every errored header is flagged `out_uncorr` and is not repaired.
- R7: With `cfg_discard_en` at 1, a cell flagged uncorrectable never raises `out_valid`. With `cfg_discard_en` at 0, that cell is forwarded byte for byte as received.
- R8: With `cfg_regen_en` at 1, output byte 4 equals the CRC of the output header bytes, XORed with 0x55 when `cfg_coset_en` is 1.
- R9: Byte i of a cell is output on the clock edge after the edge that accepts byte i of the next cell. `out_sof` marks output byte 0. Payload bytes pass through unchanged. The first cell after reset produces no output until a second cell starts.
- R10: On every byte where `out_valid` is high, exactly one of `out_hdr_ok`, `out_corrected` and `out_uncorr` is high, and it holds the same value for the whole cell.
- R11: During and right after reset, `out_valid` and `out_sof` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is byte 0 of a cell |
| in_data | input | 8 | Input byte |
| cfg_correct_en | input | 1 | Allow single-bit header repair (normally 1) |
| cfg_discard_en | input | 1 | Drop unrepairable cells |
| cfg_coset_en | input | 1 | Remove the 0x55 pattern before the comparison |
| cfg_regen_en | input | 1 | Rebuild byte 4 on output |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | Output byte is byte 0 of a cell |
| out_data | output | 8 | Output byte |
| out_hdr_ok | output | 1 | Cell header was error-free |
| out_corrected | output | 1 | Cell header was repaired |
| out_uncorr | output | 1 | Cell header had an error that was not repaired |

## Verification
Repair and mode change can land on the same header decision, and the regenerated check byte must then reflect the repaired header. The bench provokes this by flipping one bit of byte 4 with regeneration and coset both on. It judges the result by the whole output cell matching the original, together with the repaired flag. The cell that follows carries a single-bit error of its own. That cell must come out unrepaired, with a check byte rebuilt over the still-errored header, which shows the mode switch and regeneration acting together in the following cycle.

// File: rtl/hec_pkg.sv
package hec_pkg;
  localparam int          HDR_BYTES = 4;
  localparam int          CW_BITS   = 8 * (HDR_BYTES + 1);
  localparam logic [7:0]  HEC_POLY  = 8'h07;
  localparam logic [7:0]  COSET_PAT = 8'h55;

  typedef struct packed {
    logic ok;
    logic fixed;
    logic bad;
  } verdict_t;

  // Bit-serial CRC of a 32-bit header, MSB first, zero start.
  function automatic logic [7:0] crc8_bits(input logic [31:0] d);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ HEC_POLY;
    end
    return c;
  endfunction

  // Error mask for a syndrome caused by one flipped codeword bit; zero if none.
  function automatic logic [CW_BITS-1:0] err_locate(input logic [7:0] syn);
    logic [CW_BITS-1:0] m;
    m = '0;
    for (int i = 0; i < 8; i++)
      if (syn == (8'h01 << i)) m[i] = 1'b1;
    for (int j = 0; j < 32; j++)
      if (syn == crc8_bits(32'h1 << j)) m[8+j] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
  import hec_pkg::*;
(
  input  logic [31:0]        hdr,
  input  logic [7:0]         rx_hec,
  input  logic               coset_en,
  output logic [7:0]         calc,
  output logic [7:0]         syn,
  output logic [CW_BITS-1:0] mask,
  output logic               single
);
  always_comb begin
    calc   = crc8_bits(hdr);
    syn    = calc ^ rx_hec ^ (coset_en ? COSET_PAT : 8'h00);
    mask   = err_locate(syn);
    single = |mask;
  end
endmodule

// File: rtl/hec_mode_fsm.sv
module hec_mode_fsm
  import hec_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fire,
  input  logic     clean,
  input  logic     single,
  input  logic     corr_en,
  output logic     mode_corr,
  output verdict_t verdict
);
  always_comb begin
    verdict.ok    = clean;
    verdict.fixed = !clean && mode_corr && corr_en && single;
    verdict.bad   = !clean && !verdict.fixed;
  end

  // Any errored header leaves correcting mode; a clean one returns to it.
  always_ff @(posedge clk) begin
    if (rst)       mode_corr <= 1'b1;
    else if (fire) mode_corr <= clean;
  end
endmodule

// File: rtl/hec_cell_buffer.sv
module hec_cell_buffer #(
  parameter int AW = 7,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 2 ** AW;
  logic [W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/hec_cell_checker.sv
module hec_cell_checker
  import hec_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  input  logic       cfg_correct_en,
  input  logic       cfg_discard_en,
  input  logic       cfg_coset_en,
  input  logic       cfg_regen_en,
  output logic       out_valid,
  output logic       out_sof,
  output logic [7:0] out_data,
  output logic       out_hdr_ok,
  output logic       out_corrected,
  output logic       out_uncorr
);
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam int AW    = IDX_W + 1;
  localparam logic [IDX_W-1:0] IDX_HEC  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CELL_BYTES - 1);

  // Byte position and bank tracking
  logic [IDX_W-1:0] cnt, idx_cur;
  logic             wb, wb_cur, started, acc_en;

  assign idx_cur = in_sof ? '0 : cnt;
  assign wb_cur  = in_sof ? ~wb : wb;
  assign acc_en  = in_valid && (in_sof || started);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      wb      <= 1'b0;
      started <= 1'b0;
    end else if (acc_en) begin
      wb      <= wb_cur;
      started <= 1'b1;
      cnt     <= (idx_cur == IDX_LAST) ? idx_cur : idx_cur + 1'b1;
    end
  end

  // Header collection and decision
  logic [31:0]        hdr_acc;
  logic               dec_fire;
  logic [7:0]         calc, syn;
  logic [CW_BITS-1:0] mask, cw_fix;
  logic               single, mode_corr;
  verdict_t           verdict;
  logic [7:0]         hec_next;

  always_ff @(posedge clk) begin
    if (acc_en && idx_cur < IDX_HEC) hdr_acc <= {hdr_acc[23:0], in_data};
  end

  assign dec_fire = acc_en && (idx_cur == IDX_HEC);

  hec_syndrome u_syn (
    .hdr(hdr_acc), .rx_hec(in_data), .coset_en(cfg_coset_en),
    .calc(calc), .syn(syn), .mask(mask), .single(single)
  );

  hec_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .fire(dec_fire), .clean(syn == 8'h00),
    .single(single), .corr_en(cfg_correct_en),
    .mode_corr(mode_corr), .verdict(verdict)
  );

  // A repaired codeword is self-consistent, so its own byte 4 is the regenerated value.
  assign cw_fix   = {hdr_acc, in_data} ^ (verdict.fixed ? mask : '0);
  assign hec_next = (cfg_regen_en && !verdict.fixed)
                    ? (calc ^ (cfg_coset_en ? COSET_PAT : 8'h00)) : cw_fix[7:0];

  // Decided cell waits here until the next cell begins
  logic               pend_have, pend_drop;
  logic [CW_BITS-1:0] pend_cw;
  verdict_t           pend_v;
  logic               oc_en, oc_drop;
  logic [CW_BITS-1:0] oc_cw;
  verdict_t           oc_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_have <= 1'b0;
      oc_en     <= 1'b0;
    end else if (dec_fire) begin
      pend_have <= 1'b1;
      pend_cw   <= {cw_fix[CW_BITS-1:8], hec_next};
      pend_v    <= verdict;
      pend_drop <= verdict.bad && cfg_discard_en;
    end else if (acc_en && in_sof) begin
      pend_have <= 1'b0;
      oc_en     <= pend_have;
      oc_cw     <= pend_cw;
      oc_v      <= pend_v;
      oc_drop   <= pend_drop;
    end
  end

  // Ping-pong cell store
  logic [7:0] q;

  hec_cell_buffer #(.AW(AW), .W(8)) u_buf (
    .clk(clk), .we(acc_en), .waddr({wb_cur, idx_cur}), .wdata(in_data),
    .re(acc_en), .raddr({~wb_cur, idx_cur}), .q(q)
  );

  // Output stages
  logic             s1_vld, s1_go;
  logic [IDX_W-1:0] s1_idx;
  logic [7:0]       hdr_byte;

  always_ff @(posedge clk) begin
    if (rst) s1_vld <= 1'b0;
    else     s1_vld <= acc_en;
    s1_idx <= idx_cur;
  end

  always_comb begin
    hdr_byte = 8'h00;
    for (int b = 0; b <= HDR_BYTES; b++)
      if (s1_idx == IDX_W'(b)) hdr_byte = oc_cw[CW_BITS-1-8*b -: 8];
  end

  assign s1_go = s1_vld && oc_en && !oc_drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_sof       <= 1'b0;
      out_hdr_ok    <= 1'b0;
      out_corrected <= 1'b0;
      out_uncorr    <= 1'b0;
    end else begin
      out_valid     <= s1_go;
      out_sof       <= s1_go && (s1_idx == '0);
      out_hdr_ok    <= s1_go && oc_v.ok;
      out_corrected <= s1_go && oc_v.fixed;
      out_uncorr    <= s1_go && oc_v.bad;
    end
    if (s1_vld) out_data <= (s1_idx <= IDX_HEC) ? hdr_byte : q;
  end
endmodule

// File: rtl/hec_cell_checker_sva.sv
module hec_cell_checker_sva (
  input logic clk,
  input logic rst,
  input logic dec_fire,
  input logic mode_corr,
  input logic fix_now,
  input logic ok_now,
  input logic cfg_correct_en,
  input logic out_valid,
  input logic out_sof,
  input logic out_hdr_ok,
  input logic out_corrected,
  input logic out_uncorr
);
  a_r3_fix_needs_corr_mode: assert property (@(posedge clk) disable iff (rst)
    (dec_fire && fix_now) |-> (mode_corr && cfg_correct_en));

  a_r5_clean_restores_mode: assert property (@(posedge clk) disable iff (rst)
    (dec_fire && ok_now) |=> mode_corr);

  a_r4_error_enters_detect: assert property (@(posedge clk) disable iff (rst)
    (dec_fire && !ok_now) |=> !mode_corr);

  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({out_hdr_ok, out_corrected, out_uncorr}) == 1));

  a_r10_flag_steady: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_sof && $past(out_valid))
      |-> $stable({out_hdr_ok, out_corrected, out_uncorr}));

  a_r9_sof_is_valid: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid);
endmodule

bind hec_cell_checker hec_cell_checker_sva chk_i (
  .clk(clk), .rst(rst), .dec_fire(dec_fire), .mode_corr(mode_corr),
  .fix_now(verdict.fixed), .ok_now(verdict.ok), .cfg_correct_en(cfg_correct_en),
  .out_valid(out_valid), .out_sof(out_sof), .out_hdr_ok(out_hdr_ok),
  .out_corrected(out_corrected), .out_uncorr(out_uncorr)
);

// File: tb/hec_cell_checker_tb_top.sv
module hec_cell_checker_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       cfg_correct_en = 1'b1, cfg_discard_en = 1'b0;
  logic       cfg_coset_en = 1'b0, cfg_regen_en = 1'b0;
  logic       out_valid, out_sof, out_hdr_ok, out_corrected, out_uncorr;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  hec_cell_checker dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .cfg_correct_en(cfg_correct_en), .cfg_discard_en(cfg_discard_en),
    .cfg_coset_en(cfg_coset_en), .cfg_regen_en(cfg_regen_en),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
    .out_hdr_ok(out_hdr_ok), .out_corrected(out_corrected), .out_uncorr(out_uncorr)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Captured output cells
  logic [7:0] rx_b [0:7][0:52];
  logic [2:0] rx_f [0:7];
  int         rx_t [0:7];
  int         rx_cnt = 0, rx_pos = 0;
  // Expected cells and input start times
  logic [7:0] ex_b [0:7][0:52];
  logic [2:0] ex_f [0:7];
  int         ex_n = 0;
  int         in_t [0:7];
  int         in_n = 0;
  logic [7:0] tx [0:52];

  always @(negedge clk) begin
    if (out_valid) begin
      if (out_sof) begin
        if (rx_cnt < 8) begin
          rx_t[rx_cnt] = cyc;
          rx_f[rx_cnt] = {out_hdr_ok, out_corrected, out_uncorr};
        end
        rx_cnt++;
        rx_pos = 0;
      end
      if (rx_cnt >= 1 && rx_cnt <= 8 && rx_pos < 53) rx_b[rx_cnt-1][rx_pos] = out_data;
      rx_pos++;
    end
  end

  function automatic logic [7:0] ref_hec(input logic [7:0] a, b, c, d);
    logic [7:0] r;
    logic [7:0] v [0:3];
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    r = 8'h00;
    for (int k = 0; k < 4; k++) begin
      r = r ^ v[k];
      for (int s = 0; s < 8; s++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic make(input logic [7:0] h0, h1, h2, h3, input logic [7:0] seed);
    tx[0] = h0; tx[1] = h1; tx[2] = h2; tx[3] = h3;
    tx[4] = ref_hec(h0, h1, h2, h3) ^ (cfg_coset_en ? 8'h55 : 8'h00);
    for (int i = 5; i < 53; i++) tx[i] = seed + 8'(i * 3);
  endtask

  task automatic expect_cell(input logic [2:0] f);
    for (int i = 0; i < 53; i++) ex_b[ex_n][i] = tx[i];
    ex_f[ex_n] = f;
    ex_n++;
  endtask

  task automatic send_cell();
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_data  = tx[i];
      if (i == 0 && in_n < 8) begin in_t[in_n] = cyc + 1; in_n++; end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
    end
  endtask

  task automatic start(input bit ce, de, co, rg);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0;
    cfg_correct_en = ce; cfg_discard_en = de; cfg_coset_en = co; cfg_regen_en = rg;
    idle(2);
    chk(!out_valid && !out_sof, "R11", "outputs in reset", {out_valid, out_sof}, 0);
    rst = 1'b0;
    rx_cnt = 0; ex_n = 0; in_n = 0;
    idle(1);
    chk(!out_valid && !out_sof, "R11", "outputs after reset", {out_valid, out_sof}, 0);
  endtask

  task automatic finish_cells(input string req);
    int bad_at;
    make(8'hF0, 8'h0F, 8'hA5, 8'h5A, 8'h77);
    send_cell();
    idle(6);
    chk(rx_cnt == ex_n, req, "cell count", rx_cnt, ex_n);
    for (int k = 0; k < ex_n && k < rx_cnt && k < 8; k++) begin
      bad_at = -1;
      for (int i = 52; i >= 0; i--) if (rx_b[k][i] !== ex_b[k][i]) bad_at = i;
      if (bad_at >= 0)
        chk(1'b0, req, $sformatf("cell %0d byte %0d", k, bad_at), rx_b[k][bad_at], ex_b[k][bad_at]);
      else
        chk(1'b1, req, "cell bytes", 0, 0);
      chk(rx_f[k] == ex_f[k], req, $sformatf("cell %0d flags ok/corr/unc", k), rx_f[k], ex_f[k]);
    end
  endtask

  // R1 R9 R10: clean cells pass unchanged with one-cell latency
  task automatic t_clean();
    start(1, 0, 0, 0);
    make(8'h00, 8'h00, 8'h00, 8'h01, 8'h10); expect_cell(3'b100); send_cell();
    idle(4);
    chk(rx_cnt == 0, "R9", "no output before next cell", rx_cnt, 0);
    make(8'h12, 8'h34, 8'h56, 8'h78, 8'h20); expect_cell(3'b100); send_cell();
    make(8'hFF, 8'h00, 8'hC3, 8'h3C, 8'h30); expect_cell(3'b100); send_cell();
    finish_cells("R1");
    chk(rx_t[1] == in_t[2] + 1, "R9", "latency cell1", rx_t[1], in_t[2] + 1);
    chk(rx_t[2] == in_t[3] + 1, "R9", "latency cell2", rx_t[2], in_t[3] + 1);
  endtask

  // R2: coset pattern removed before comparison
  task automatic t_coset();
    start(0, 0, 1, 0);
    make(8'h11, 8'h22, 8'h33, 8'h44, 8'h40); expect_cell(3'b100); send_cell();
    make(8'h55, 8'h66, 8'h77, 8'h88, 8'h50);
    tx[4] = ref_hec(8'h55, 8'h66, 8'h77, 8'h88);
    expect_cell(3'b001); send_cell();
    finish_cells("R2");
  endtask

  // R3 R5: repair, detection mode, return to correction
  task automatic t_correct();
    start(1, 0, 0, 0);
    make(8'h01, 8'h23, 8'h45, 8'h67, 8'h60); expect_cell(3'b010); tx[1] ^= 8'h08; send_cell();
    make(8'h89, 8'hAB, 8'hCD, 8'hEF, 8'h70); tx[4] ^= 8'h01; expect_cell(3'b001); send_cell();
    make(8'h10, 8'h20, 8'h30, 8'h40, 8'h80); expect_cell(3'b100); send_cell();
    idle(3);
    make(8'h5A, 8'h5A, 8'h00, 8'h02, 8'h90); expect_cell(3'b010); tx[0] ^= 8'h80; send_cell();
    finish_cells("R3/R5");
  endtask

  // R4 R5 R7: double error, then single error while detecting, then clean
  task automatic t_multi();
    start(1, 0, 0, 0);
    make(8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'hA0); tx[2] ^= 8'h11; expect_cell(3'b001); send_cell();
    make(8'h1A, 8'h1B, 8'h1C, 8'h1D, 8'hB0); tx[3] ^= 8'h04; expect_cell(3'b001); send_cell();
    make(8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'hC0); expect_cell(3'b100); send_cell();
    finish_cells("R4");
  endtask

  // R6: correction disabled
  task automatic t_nocorr();
    start(0, 0, 0, 0);
    make(8'h33, 8'h44, 8'h55, 8'h66, 8'hD0); tx[2] ^= 8'h20; expect_cell(3'b001); send_cell();
    make(8'h34, 8'h45, 8'h56, 8'h67, 8'hE0); expect_cell(3'b100); send_cell();
    finish_cells("R6");
  endtask

  // R7: unrepairable cell dropped, with idle gaps
  task automatic t_discard();
    start(0, 1, 0, 0);
    make(8'h01, 8'h02, 8'h03, 8'h04, 8'h01); expect_cell(3'b100); send_cell();
    idle(3);
    make(8'h05, 8'h06, 8'h07, 8'h08, 8'h02); tx[1] ^= 8'h01; send_cell();
    idle(2);
    make(8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h03); expect_cell(3'b100); send_cell();
    finish_cells("R7");
  endtask

  // R8: regeneration with coset, after repair and on an unrepaired header
  task automatic t_regen();
    start(1, 0, 1, 1);
    make(8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h11); expect_cell(3'b010); tx[4] ^= 8'h20; send_cell();
    make(8'hCA, 8'hFE, 8'hBA, 8'hBE, 8'h22); tx[3] ^= 8'h01; send_cell();
    expect_cell(3'b001);
    ex_b[ex_n-1][4] = ref_hec(tx[0], tx[1], tx[2], tx[3]) ^ 8'h55;
    finish_cells("R8");
  endtask

  initial begin
    t_clean();
    t_coset();
    t_correct();
    t_multi();
    t_nocorr();
    t_discard();
    t_regen();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule